// File: doc/BRIEF.md
# Quad DAC Serial Command Front End

This block is the digital front end of a four-channel, 8-bit voltage DAC. It accepts frames over a four-wire serial link: a serial clock, an active-low select, a data input and a data output. A frame opens with a `1` start bit. A 2-bit opcode follows, then the channel number, then an 8-bit data phase. The serial pins are brought into the system clock domain through synchronizers. Edges of the serial clock are found by comparing the current and previous synchronized samples.

Each channel has two registers:
- a live code register, which feeds the converter;
- a nonvolatile shadow register, modelled as flops. A save into the shadow takes a programmable number of system clocks.

While a save is running, the block pulls the ready line low and discards any new command. A recall reset copies every shadow into its live register. A separate power-on reset puts the shadows at their initial code. The mute input forces all presented codes to zero without touching the stored values.

Top module: `qdac_serial_front`

## Requirements
- R1: After power-on reset (`por_n` and `rst_n` low), every shadow and every presented code equals `INIT_CODE`. The data output is disabled and the ready line is not pulled.
- R2: While `cs_n_i` is low, zero bits sampled before the first one are discarded. The frame opens on the first `1` sampled at a rising serial clock edge.
- R3: After the start bit, the frame carries the 2-bit opcode, then the 2-bit channel number, then 8 data bits, all MSB first and sampled on rising serial clock edges. Channel `k` occupies `codes_o[8k+7:8k]`.
- R4: Opcode `01` writes the data byte into the addressed live register once the 8th data bit is taken. The other channels keep their codes.
- R5: Opcode `00` reads the addressed live register. `sdo_en_o` rises on the first falling serial clock edge after the last address bit, and `sdo_o` presents bit 7 there. Each later falling edge presents the next lower bit. The read leaves every live code unchanged.
- R6: `sdo_en_o` is low outside the data phase of an accepted read frame.
- R7: Opcode `10` copies the addressed live code into its shadow when the save delay ends. Live writes made afterwards do not change the shadow, which a recall reset (`rst_n` pulse) shows.
- R8: Opcode `11` copies all four live codes into their shadows.
- R9: After a save frame completes, `rdy_pull_o` is high for exactly `NV_WRITE_CYCLES` system clocks. Any frame whose address phase ends while it is high has no effect: no write, no read output, no save.
- R10: Raising `cs_n_i` at any point aborts the frame. The target register stays unchanged, `sdo_en_o` drops, and the decoder waits for a new start bit.
- R11: While `mute_i` is high every presented code is 0. Stored codes are kept and reappear when mute is released.
- R12: A recall reset (`rst_n` alone) loads each live code from its shadow and leaves the shadows unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous recall reset; live codes load from shadows |
| por_n | input | 1 | Active-low synchronous power-on reset of the shadow store |
| sclk_i | input | 1 | Serial clock |
| cs_n_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data in |
| mute_i | input | 1 | Forces presented codes to zero |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Output enable for the serial data pin (low = high impedance) |
| rdy_pull_o | output | 1 | High while a save is in progress (pulls the ready line low) |
| codes_o | output | NCH*W | Presented codes, channel k at bits [W*k+W-1:W*k] |

## Verification
The bench uses four channels, 8-bit codes, an initial code of 0x80 and a save delay of 700 system clocks. The serial clock half period is 8 system clocks. With these values one save window is longer than two complete frames, so a write and a read can both be issued and finish inside the busy window, and both can be shown to have no effect. An initial code of 0x80 differs from zero, so mute and recall produce values that can be told apart at the outputs.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [1:0] {
        OP_RD_LIVE  = 2'b00,
        OP_WR_LIVE  = 2'b01,
        OP_SAVE_ONE = 2'b10,
        OP_SAVE_ALL = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_ADDR = 2'd2,
        ST_DATA = 2'd3
    } st_e;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int                WIDTH   = 3,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d_i;
        for (int k = 1; k < STAGES; k++) begin
            st_d[k] = st_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
    end

    assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/qdac_frame_dec.sv
module qdac_frame_dec import qdac_pkg::*; #(
    parameter  int NCH = 4,
    parameter  int W   = 8,
    localparam int AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             sel_act,
    input  logic             din,
    input  logic             busy_i,
    input  logic [NCH*W-1:0] live_i,
    output logic [AW-1:0]    addr_o,
    output logic [W-1:0]     data_o,
    output logic             wr_live_o,
    output logic             save_one_o,
    output logic             save_all_o,
    output logic             sdo_o,
    output logic             sdo_en_o,
    output logic             in_data_o
);

    localparam int CW = $clog2(W + AW + 2);

    typedef struct packed {
        st_e           st;
        logic [CW-1:0] cnt;
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [W-1:0]  din_sh;
        logic [W-1:0]  dout_sh;
        logic          arm;
        logic          oe;
        logic          ign;
        logic          wr;
        logic          s1;
        logic          sa;
    } dec_t;

    dec_t q, d;
    logic [AW:0]   addr_ext;
    logic [AW-1:0] addr_nxt;

    assign addr_ext = {q.addr, din};
    assign addr_nxt = addr_ext[AW-1:0];

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        d.s1 = 1'b0;
        d.sa = 1'b0;
        if (!sel_act) begin
            // select released: abandon whatever was in flight
            d.st  = ST_IDLE;
            d.cnt = '0;
            d.arm = 1'b0;
            d.oe  = 1'b0;
        end else if (sclk_rise) begin
            case (q.st)
                ST_IDLE: begin
                    if (din) begin
                        d.st  = ST_CMD;
                        d.cnt = '0;
                    end
                end
                ST_CMD: begin
                    d.op = {q.op[0], din};
                    if (q.cnt == CW'(1)) begin
                        d.st  = ST_ADDR;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_ADDR: begin
                    d.addr = addr_nxt;
                    if (q.cnt == CW'(AW - 1)) begin
                        d.st  = ST_DATA;
                        d.cnt = '0;
                        d.ign = busy_i;
                        if (op_e'(q.op) == OP_RD_LIVE && !busy_i) begin
                            d.arm     = 1'b1;
                            d.dout_sh = live_i[int'(addr_nxt)*W +: W];
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    d.din_sh = {q.din_sh[W-2:0], din};
                    if (q.cnt == CW'(W - 1)) begin
                        d.st  = ST_IDLE;
                        d.cnt = '0;
                        d.arm = 1'b0;
                        d.oe  = 1'b0;
                        if (!q.ign) begin
                            case (op_e'(q.op))
                                OP_WR_LIVE:  d.wr = 1'b1;
                                OP_SAVE_ONE: d.s1 = 1'b1;
                                OP_SAVE_ALL: d.sa = 1'b1;
                                default:     ;
                            endcase
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end else if (sclk_fall) begin
            if (q.arm) begin
                d.arm = 1'b0;
                d.oe  = 1'b1;
            end else if (q.oe) begin
                d.dout_sh = {q.dout_sh[W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr_o     = q.addr;
    assign data_o     = q.din_sh;
    assign wr_live_o  = q.wr;
    assign save_one_o = q.s1;
    assign save_all_o = q.sa;
    assign sdo_o      = q.dout_sh[W-1];
    assign sdo_en_o   = q.oe;
    assign in_data_o  = (q.st == ST_DATA);

endmodule

// File: rtl/qdac_nv_store.sv
module qdac_nv_store #(
    parameter  int           NCH       = 4,
    parameter  int           W         = 8,
    parameter  int           NV_CYCLES = 2000,
    parameter  logic [W-1:0] INIT_CODE = 8'h80,
    localparam int           AW        = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int           TW        = $clog2(NV_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             save_one_i,
    input  logic             save_all_i,
    input  logic [AW-1:0]    sel_i,
    input  logic [NCH*W-1:0] live_i,
    output logic [NCH*W-1:0] shadow_o,
    output logic             busy_o
);

    typedef struct packed {
        logic [NCH*W-1:0] shadow;
        logic [NCH*W-1:0] pend;
        logic [NCH-1:0]   mask;
        logic [TW-1:0]    tmr;
    } nv_t;

    nv_t q, d;
    logic [NCH-1:0] sel_mask;
    logic [NCH-1:0] commit;

    assign sel_mask = NCH'(1) << sel_i;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_commit
            assign commit[c] = q.mask[c] && (q.tmr == TW'(1));
        end
    endgenerate

    always_comb begin
        d = q;
        if (q.tmr != '0) begin
            d.tmr = q.tmr - 1'b1;
            for (int k = 0; k < NCH; k++) begin
                if (commit[k]) d.shadow[k*W +: W] = q.pend[k*W +: W];
            end
        end else if (save_one_i || save_all_i) begin
            d.pend = live_i;
            d.mask = save_all_i ? {NCH{1'b1}} : sel_mask;
            d.tmr  = TW'(NV_CYCLES);
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            q.shadow <= {NCH{INIT_CODE}};
            q.pend   <= '0;
            q.mask   <= '0;
            q.tmr    <= '0;
        end else begin
            q <= d;
        end
    end

    assign shadow_o = q.shadow;
    assign busy_o   = (q.tmr != '0);

endmodule

// File: rtl/qdac_serial_front.sv
module qdac_serial_front import qdac_pkg::*; #(
    parameter int           NCH             = 4,
    parameter int           W               = 8,
    parameter int           NV_WRITE_CYCLES = 2000,
    parameter logic [W-1:0] INIT_CODE       = 8'h80,
    parameter int           SYNC_STAGES     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             sclk_i,
    input  logic             cs_n_i,
    input  logic             sdi_i,
    input  logic             mute_i,
    output logic             sdo_o,
    output logic             sdo_en_o,
    output logic             rdy_pull_o,
    output logic [NCH*W-1:0] codes_o
);

    localparam int AW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic [NCH*W-1:0] live;
        logic             sclk_prev;
    } top_t;

    top_t top_q, top_d;

    logic [2:0]       pins_s;
    logic             cs_n_s, sclk_s, sdi_s;
    logic             sclk_rise, sclk_fall;
    logic [AW-1:0]    dec_addr;
    logic [W-1:0]     dec_data;
    logic             wr_stb, save_one, save_all, dec_in_data;
    logic [NCH*W-1:0] shadow_flat;
    logic [NCH*W-1:0] live_flat;

    qdac_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n_i, sclk_i, sdi_i}),
        .q_o   (pins_s)
    );

    assign cs_n_s    = pins_s[2];
    assign sclk_s    = pins_s[1];
    assign sdi_s     = pins_s[0];
    assign sclk_rise = sclk_s & ~top_q.sclk_prev;
    assign sclk_fall = ~sclk_s & top_q.sclk_prev;
    assign live_flat = top_q.live;

    qdac_frame_dec #(
        .NCH (NCH),
        .W   (W)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .sel_act    (~cs_n_s),
        .din        (sdi_s),
        .busy_i     (rdy_pull_o),
        .live_i     (top_q.live),
        .addr_o     (dec_addr),
        .data_o     (dec_data),
        .wr_live_o  (wr_stb),
        .save_one_o (save_one),
        .save_all_o (save_all),
        .sdo_o      (sdo_o),
        .sdo_en_o   (sdo_en_o),
        .in_data_o  (dec_in_data)
    );

    qdac_nv_store #(
        .NCH       (NCH),
        .W         (W),
        .NV_CYCLES (NV_WRITE_CYCLES),
        .INIT_CODE (INIT_CODE)
    ) u_nv (
        .clk        (clk),
        .por_n      (por_n),
        .save_one_i (save_one),
        .save_all_i (save_all),
        .sel_i      (dec_addr),
        .live_i     (top_q.live),
        .shadow_o   (shadow_flat),
        .busy_o     (rdy_pull_o)
    );

    always_comb begin
        top_d           = top_q;
        top_d.sclk_prev = sclk_s;
        if (wr_stb) top_d.live[int'(dec_addr)*W +: W] = dec_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q.live      <= shadow_flat;
            top_q.sclk_prev <= 1'b0;
        end else begin
            top_q <= top_d;
        end
    end

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_out
            assign codes_o[c*W +: W] = mute_i ? '0 : top_q.live[c*W +: W];
        end
    endgenerate

endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
    parameter int NCH       = 4,
    parameter int W         = 8,
    parameter int NV_CYCLES = 2000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             por_n,
    input logic             cs_n_i,
    input logic             sdo_en_o,
    input logic             rdy_pull_o,
    input logic [NCH*W-1:0] live_v,
    input logic [NCH*W-1:0] shadow_v,
    input logic             wr_stb,
    input logic             in_data
);

    localparam int RW = $clog2(NV_CYCLES + 2);

    logic [RW-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (!por_n)          busy_run <= '0;
        else if (rdy_pull_o) busy_run <= busy_run + 1'b1;
        else                 busy_run <= '0;
    end

    // R6: the data pin is only driven inside a frame's data phase
    a_r6_oe_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_en_o |-> in_data);

    // R10: a select held high releases the data pin
    a_r10_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n_i, 3) && $past(cs_n_i, 2) && $past(cs_n_i)) |-> !sdo_en_o);

    // R4: live codes move only on a decoded write strobe
    a_r4_live_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && live_v != $past(live_v)) |-> $past(wr_stb));

    // R7: shadows move only while a save is running
    a_r7_shadow_by_save: assert property (@(posedge clk) disable iff (!por_n)
        ($past(por_n) && shadow_v != $past(shadow_v)) |-> $past(rdy_pull_o));

    // R9: busy never outlasts the save delay
    a_r9_busy_bound: assert property (@(posedge clk) disable iff (!por_n)
        busy_run <= RW'(NV_CYCLES));

endmodule

bind qdac_serial_front qdac_checker #(
    .NCH       (NCH),
    .W         (W),
    .NV_CYCLES (NV_WRITE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_n      (por_n),
    .cs_n_i     (cs_n_i),
    .sdo_en_o   (sdo_en_o),
    .rdy_pull_o (rdy_pull_o),
    .live_v     (live_flat),
    .shadow_v   (shadow_flat),
    .wr_stb     (wr_stb),
    .in_data    (dec_in_data)
);

// File: tb/sim_qdac_serial_front.sv
module sim_qdac_serial_front;

    localparam int         NCH  = 4;
    localparam int         W    = 8;
    localparam int         NVC  = 700;
    localparam logic [7:0] INIT = 8'h80;
    localparam int         HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0, por_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, mute = 1'b0;
    logic sdo_o, sdo_en_o, rdy_pull_o;
    logic [NCH*W-1:0] codes_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0] live_m [NCH];
    logic [7:0] nv_m [NCH];
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];
    event rd_ev;
    int busy_run = 0, last_busy = 0;

    always #2.5ns clk = ~clk;

    qdac_serial_front #(
        .NCH(NCH), .W(W), .NV_WRITE_CYCLES(NVC), .INIT_CODE(INIT), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .sclk_i(sclk), .cs_n_i(cs_n),
        .sdi_i(sdi), .mute_i(mute), .sdo_o(sdo_o), .sdo_en_o(sdo_en_o),
        .rdy_pull_o(rdy_pull_o), .codes_o(codes_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_codes(input string req);
        for (int c = 0; c < NCH; c++) chk(req, codes_o[c*W +: W], live_m[c]);
    endtask

    // scoreboard monitor for read data
    initial begin
        forever begin
            @(rd_ev);
            while (got_q.size() > 0 && exp_q.size() > 0)
                chk("R5 read byte", got_q.pop_front(), exp_q.pop_front());
        end
    end

    // busy length monitor
    always @(negedge clk) begin
        if (rdy_pull_o) busy_run <= busy_run + 1;
        else if (busy_run != 0) begin
            last_busy <= busy_run;
            busy_run  <= 0;
        end
    end

    task automatic sbit(input logic b, output logic so, output logic soe);
        sdi = b;
        repeat (HALF) @(negedge clk);
        so  = sdo_o;
        soe = sdo_en_o;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    // keep: bits sent after the start bit (12 = complete frame)
    task automatic frame(input logic [1:0] op, input logic [1:0] ch, input logic [7:0] dat,
                         input int lead, input int keep,
                         output logic [7:0] rd, output int oe_cnt);
        logic [11:0] v;
        logic so, soe;
        v = {op, ch, dat};
        rd = '0;
        oe_cnt = 0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < lead; i++) sbit(1'b0, so, soe);
        sbit(1'b1, so, soe);
        for (int i = 0; i < keep; i++) begin
            sbit(v[11-i], so, soe);
            if (i >= 4) begin
                rd = {rd[6:0], so};
                if (soe) oe_cnt++;
            end
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4*HALF) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] ch, input logic [7:0] dat, input int lead);
        logic [7:0] r; int o;
        frame(2'b01, ch, dat, lead, 12, r, o);
        live_m[ch] = dat;
    endtask

    task automatic rd_chan(input logic [1:0] ch, output int o);
        logic [7:0] r;
        exp_q.push_back(live_m[ch]);
        frame(2'b00, ch, 8'h00, 0, 12, r, o);
        got_q.push_back(r);
        -> rd_ev;
    endtask

    task automatic recall;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        for (int c = 0; c < NCH; c++) live_m[c] = nv_m[c];
    endtask

    task automatic wait_idle;
        while (rdy_pull_o) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [7:0] r;
        int o;
        for (int c = 0; c < NCH; c++) begin live_m[c] = INIT; nv_m[c] = INIT; end
        repeat (10) @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk_codes("R1 reset codes");
        chk("R1 sdo_en after reset", sdo_en_o, 1'b0);
        chk("R1 busy after reset", rdy_pull_o, 1'b0);

        // R2 leading zeros, R3 framing, R4 write
        wr(2'd2, 8'h5A, 3);
        chk_codes("R2 R4 write after leading zeros");
        wr(2'd0, 8'hC3, 0);
        wr(2'd1, 8'h11, 1);
        wr(2'd3, 8'hFE, 0);
        chk_codes("R3 R4 writes per channel");

        // R5 reads, R6 enable during data
        rd_chan(2'd2, o);
        chk("R5 sdo_en across data phase", o, 8);
        rd_chan(2'd3, o);
        chk("R5 sdo_en across data phase ch3", o, 8);
        chk_codes("R5 read leaves codes");
        chk("R6 sdo_en idle after read", sdo_en_o, 1'b0);
        frame(2'b01, 2'd0, 8'hC3, 0, 12, r, o);
        chk("R6 sdo_en stays low in write frame", o, 0);

        // R10 aborted write, aborted read
        frame(2'b01, 2'd1, 8'h77, 0, 6, r, o);
        chk_codes("R10 aborted write keeps code");
        frame(2'b00, 2'd0, 8'h00, 0, 7, r, o);
        chk("R10 read partial enabled", o, 3);
        chk("R10 sdo_en released on select high", sdo_en_o, 1'b0);
        wr(2'd1, 8'h2B, 0);
        chk_codes("R10 decoder restarts after abort");

        // R7 save one channel; R9 busy window ignores commands
        frame(2'b10, 2'd2, 8'h00, 0, 12, r, o);
        nv_m[2] = live_m[2];
        chk("R9 busy after save", rdy_pull_o, 1'b1);
        frame(2'b01, 2'd0, 8'h00, 0, 12, r, o);
        chk_codes("R9 write ignored while busy");
        frame(2'b00, 2'd1, 8'h00, 0, 12, r, o);
        chk("R9 read ignored while busy", o, 0);
        wait_idle();
        chk("R9 busy length", last_busy, NVC);
        chk_codes("R9 codes after busy");

        wr(2'd2, 8'h33, 0);
        chk_codes("R7 live rewrite");
        recall();
        chk_codes("R7 R12 recall shows single save");

        // R8 save all
        wr(2'd0, 8'h01, 0);
        wr(2'd1, 8'h82, 0);
        wr(2'd2, 8'hA4, 0);
        wr(2'd3, 8'h7F, 0);
        frame(2'b11, 2'd0, 8'h00, 0, 12, r, o);
        for (int c = 0; c < NCH; c++) nv_m[c] = live_m[c];
        wait_idle();
        chk("R8 busy length", last_busy, NVC);
        wr(2'd1, 8'h00, 0);
        chk_codes("R8 live change after save");
        recall();
        chk_codes("R8 R12 recall shows all saved");
        recall();
        chk_codes("R12 second recall keeps shadows");

        // R11 mute
        mute = 1'b1;
        repeat (2) @(negedge clk);
        for (int c = 0; c < NCH; c++) chk("R11 muted code", codes_o[c*W +: W], 8'h00);
        mute = 1'b0;
        repeat (2) @(negedge clk);
        chk_codes("R11 codes back after mute");

        // R1 power-on reset restores initial shadows
        por_n = 1'b0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        for (int c = 0; c < NCH; c++) begin nv_m[c] = INIT; live_m[c] = INIT; end
        chk_codes("R1 power-on codes");

        repeat (10) @(negedge clk);
        chk("R5 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule